// File: doc/BRIEF.md
# Configurable PWM Channel Generator

This block drives one pulse-width-modulated output from a channel tick that can be picked from several sources. One source is the system clock scaled down by a power of two from 1 to 1024. The other two are two independent linear dividers. Each divider takes its own power-of-two scaled tick and divides it again by an integer. A period counter advances on each channel tick. The output level follows from comparing that counter with a duty value.

Two alignments are offered. In left alignment the counter runs upward and wraps. In center alignment it climbs and then descends, so one period lasts twice as many ticks and the pulse sits symmetrically about the middle of the period. Channels that share a period can therefore be given duty values that never overlap. A polarity bit chooses the level each period begins with. The period, duty, polarity and alignment inputs are captured into shadow registers only at a period boundary, or at any time while the channel is disabled, so that no glitch occurs. A one-cycle strobe marks each period boundary.

Top module: `pwm_channel`

## Requirements
- R1: Clock select codes 0 to 10 give one channel tick every 2^code system cycles, so a left-aligned period of P ticks lasts P·2^code cycles.
- R2: Code 11 selects divider A and code 12 selects divider B. A divider gives one tick every 2^s·d cycles, where s is its own scale code and d its divide value. A divider with d = 0, or with a scale code above 10, produces no ticks.
- R3: Clock select codes 13 to 15 produce no ticks. The counter then holds and no period strobe appears.
- R4: In left alignment a period lasts P ticks. `period_end` is high for one cycle each time the counter returns to zero.
- R5: In center alignment the counter rises from 0 to P and then falls back to 1. One period therefore lasts 2·P ticks.
- R6: In left alignment the output stays at the start level for min(D,P) ticks after the strobe, then holds the opposite level for the rest of the period.
- R7: In center alignment the output spends D ticks at the start level after the strobe, then 2·(P−D) ticks at the opposite level centred on the counter peak, then D ticks back at the start level.
- R8: The start level of each period equals the polarity bit (0 = starts low, 1 = starts high).
- R9: D = 0 gives the opposite level for the whole period. D ≥ P gives the start level for the whole period. Neither case produces a pulse.
- R10: Period, duty, polarity and alignment are sampled only at a period boundary. A change during a period first shows in the next period. A period value of 0 behaves as 1.
- R11: With `en` low the counter, prescaler and dividers are held cleared. The output sits at the start level, no strobe is issued, and the shadow registers follow the inputs.
- R12: After reset the output is low, `period_end` is low and left alignment is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel run enable |
| clk_sel | input | 4 | Tick source: 0–10 power-of-two scale, 11 divider A, 12 divider B |
| pre_a | input | 4 | Power-of-two scale code feeding divider A |
| div_a | input | 8 | Linear divide value of divider A (0 = off) |
| pre_b | input | 4 | Power-of-two scale code feeding divider B |
| div_b | input | 8 | Linear divide value of divider B (0 = off) |
| period | input | 16 | Period length P in ticks (0 treated as 1) |
| duty | input | 16 | Duty threshold D in ticks |
| pol | input | 1 | Start level of each period |
| center | input | 1 | 1 = center alignment, 0 = left alignment |
| pwm_out | output | 1 | PWM waveform |
| period_end | output | 1 | One-cycle strobe at each period boundary |

## Verification
The assertions rely on the period and duty values reaching the counter only through the shadow registers. This keeps the counter inside its range, because a new period length is only taken up when the counter stands at zero. They also rely on `en` being a plain synchronous level, with no hidden protocol. The stimulus changes the configuration at arbitrary points of a period and then judges only complete periods that begin after the next boundary. Random values stay small enough that every period ends well within the bench time limit. Directed cases then cover the disabled state, the silent clock codes, an idle divider, the largest prescale, a period value of zero and the two duty extremes.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;

  // Low-bit mask whose all-ones state marks a tick of a 2^k scale.
  function automatic logic [31:0] pre_mask(input int k);
    return (32'd1 << k) - 32'd1;
  endfunction

  // A period register of zero counts as one tick.
  function automatic logic [31:0] eff_period(input logic [31:0] p);
    return (p == 32'd0) ? 32'd1 : p;
  endfunction

  // Opposite-level test. On the way down the compare is strict, so the
  // start-level run around the wrap and the opposite-level run around the
  // peak are both of even length and symmetric.
  function automatic logic beyond_duty(input logic [31:0] cnt,
                                       input logic [31:0] duty,
                                       input logic        down);
    return down ? (cnt > duty) : (cnt >= duty);
  endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_chan_pkg::*;
#(
  parameter int PRE_STAGES = 11,
  parameter int SEL_W      = 4,
  parameter int DIV_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [SEL_W-1:0] pre_a,
  input  logic [DIV_W-1:0] div_a,
  input  logic [SEL_W-1:0] pre_b,
  input  logic [DIV_W-1:0] div_b,
  output logic             tick
);
  localparam int PRE_W = PRE_STAGES - 1;
  localparam int NLIN  = 2;
  localparam int SEL_A = PRE_STAGES;
  localparam int SEL_B = PRE_STAGES + 1;

  logic [PRE_W-1:0]      pre_cnt;
  logic [PRE_STAGES-1:0] pre_tick;
  logic [SEL_W-1:0]      lin_sel [NLIN];
  logic [DIV_W-1:0]      lin_div [NLIN];
  logic [NLIN-1:0]       lin_tick;

  assign lin_sel[0] = pre_a;
  assign lin_sel[1] = pre_b;
  assign lin_div[0] = div_a;
  assign lin_div[1] = div_b;

  // Shared free-running scale counter, cleared while idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pre_cnt <= '0;
    else if (!en) pre_cnt <= '0;
    else         pre_cnt <= pre_cnt + 1'b1;
  end

  for (genvar k = 0; k < PRE_STAGES; k++) begin : g_scale
    localparam logic [PRE_W-1:0] MASK = PRE_W'(pre_mask(k));
    assign pre_tick[k] = (pre_cnt & MASK) == MASK;
  end

  for (genvar i = 0; i < NLIN; i++) begin : g_lin
    logic [DIV_W-1:0] dcnt;
    logic             src;

    always_comb begin
      src = 1'b0;
      for (int k = 0; k < PRE_STAGES; k++)
        if (lin_sel[i] == SEL_W'(k)) src = pre_tick[k];
    end

    assign lin_tick[i] = en && src && (lin_div[i] != '0) &&
                         (dcnt >= DIV_W'(lin_div[i] - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          dcnt <= '0;
      else if (!en || lin_div[i] == '0)    dcnt <= '0;
      else if (src)                        dcnt <= lin_tick[i] ? '0 : dcnt + 1'b1;
    end
  end

  always_comb begin
    tick = 1'b0;
    if (en) begin
      for (int k = 0; k < PRE_STAGES; k++)
        if (clk_sel == SEL_W'(k)) tick = pre_tick[k];
      if (clk_sel == SEL_W'(SEL_A)) tick = lin_tick[0];
      if (clk_sel == SEL_W'(SEL_B)) tick = lin_tick[1];
    end
  end

  // R1: the scale counter advances exactly one step per running cycle
  assert_pre_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> pre_cnt == PRE_W'($past(pre_cnt) + 1'b1));

  // R3: codes above the second divider never tick
  assert_idle_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel > SEL_W'(SEL_B)) |-> !tick);

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  input  logic             pol,
  input  logic             center,
  output logic [CNT_W-1:0] cnt,
  output dir_e             dir,
  output logic [CNT_W-1:0] prd_s,
  output logic [CNT_W-1:0] dty_s,
  output logic             pol_s,
  output logic             period_end
);
  logic             ctr_s;
  logic [CNT_W-1:0] p_eff;
  logic [CNT_W-1:0] top_up;
  logic             wrap;
  logic             load;

  assign p_eff  = CNT_W'(eff_period(32'(prd_s)));
  assign top_up = p_eff - 1'b1;
  assign wrap   = en && tick &&
                  (ctr_s ? (dir == DIR_DOWN && cnt == CNT_W'(1)) : (cnt == top_up));
  assign load   = !en || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      dir        <= DIR_UP;
      prd_s      <= '0;
      dty_s      <= '0;
      pol_s      <= 1'b0;
      ctr_s      <= 1'b0;
      period_end <= 1'b0;
    end else begin
      period_end <= wrap;
      if (load) begin
        prd_s <= period;
        dty_s <= duty;
        pol_s <= pol;
        ctr_s <= center;
      end
      if (!en || wrap) begin
        cnt <= '0;
        dir <= DIR_UP;
      end else if (tick) begin
        if (!ctr_s) begin
          cnt <= cnt + 1'b1;
        end else if (dir == DIR_UP) begin
          cnt <= cnt + 1'b1;
          if (cnt == top_up) dir <= DIR_DOWN;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R5: counter stays inside 0..P (center) or 0..P-1 (left)
  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_s ? (cnt <= p_eff) : (cnt < p_eff));

  // R4: the strobe coincides with the counter back at zero, counting up
  assert_end_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> (cnt == '0 && dir == DIR_UP));

  // R10: shadow registers move only at a boundary or while idle
  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(dty_s) && $stable(prd_s) && $stable(pol_s) && $stable(ctr_s)));

  // R11: disabling clears the counter and suppresses the strobe
  assert_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && !period_end));

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  dir_e             dir,
  input  logic [CNT_W-1:0] prd_s,
  input  logic [CNT_W-1:0] dty_s,
  input  logic             pol_s,
  output logic             pwm_out
);
  logic second;

  assign second  = beyond_duty(32'(cnt), 32'(dty_s), dir == DIR_DOWN);
  assign pwm_out = (en && second) ? !pol_s : pol_s;

  // R9: zero duty keeps the opposite level throughout
  assert_zero_duty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dty_s == '0) |-> (pwm_out != pol_s));

  // R9: duty at or above the period keeps the start level throughout
  assert_full_duty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(dty_s) >= eff_period(32'(prd_s))) |-> (pwm_out == pol_s));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DIV_W      = 8,
  parameter int SEL_W      = 4,
  parameter int PRE_STAGES = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [SEL_W-1:0] pre_a,
  input  logic [DIV_W-1:0] div_a,
  input  logic [SEL_W-1:0] pre_b,
  input  logic [DIV_W-1:0] div_b,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  input  logic             pol,
  input  logic             center,
  output logic             pwm_out,
  output logic             period_end
);
  logic             tick;
  logic [CNT_W-1:0] cnt;
  dir_e             dir;
  logic [CNT_W-1:0] prd_s;
  logic [CNT_W-1:0] dty_s;
  logic             pol_s;

  pwm_tick_gen #(
    .PRE_STAGES(PRE_STAGES), .SEL_W(SEL_W), .DIV_W(DIV_W)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en), .clk_sel(clk_sel),
    .pre_a(pre_a), .div_a(div_a), .pre_b(pre_b), .div_b(div_b),
    .tick(tick)
  );

  pwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
    .period(period), .duty(duty), .pol(pol), .center(center),
    .cnt(cnt), .dir(dir), .prd_s(prd_s), .dty_s(dty_s), .pol_s(pol_s),
    .period_end(period_end)
  );

  pwm_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt), .dir(dir),
    .prd_s(prd_s), .dty_s(dty_s), .pol_s(pol_s), .pwm_out(pwm_out)
  );

  // R12: out of reset the waveform rests low with no strobe
  assert_reset_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pwm_out && !period_end));

endmodule

// File: tb/tb_pwm_channel.sv
module tb_pwm_channel;
  localparam int TMO = 20000;
  localparam int WATCHDOG = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  clk_sel = '0, pre_a = '0, pre_b = '0;
  logic [7:0]  div_a = '0, div_b = '0;
  logic [15:0] period = '0, duty = '0;
  logic        pol = 1'b0, center = 1'b0;
  logic        pwm_out, period_end;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  pwm_channel dut (
    .clk(clk), .rst_n(rst_n), .en(en), .clk_sel(clk_sel),
    .pre_a(pre_a), .div_a(div_a), .pre_b(pre_b), .div_b(div_b),
    .period(period), .duty(duty), .pol(pol), .center(center),
    .pwm_out(pwm_out), .period_end(period_end)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tick_len(input int sel, input int pa, input int da,
                                  input int pb, input int db);
    if (sel <= 10) return 1 << sel;
    if (sel == 11) return (pa > 10 || da == 0) ? 0 : (1 << pa) * da;
    if (sel == 12) return (pb > 10 || db == 0) ? 0 : (1 << pb) * db;
    return 0;
  endfunction

  task automatic apply(input int sel, input int pa, input int da, input int pb,
                       input int db, input int p, input int d, input bit pl,
                       input bit c);
    clk_sel = 4'(sel); pre_a = 4'(pa); div_a = 8'(da); pre_b = 4'(pb);
    div_b = 8'(db); period = 16'(p); duty = 16'(d); pol = pl; center = c;
  endtask

  task automatic wait_end();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!period_end && n < TMO);
    if (!period_end) check("R4 strobe timeout", 0, 1);
  endtask

  task automatic count_strobes(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (period_end) c++;
    end
  endtask

  // Counts one whole period starting from the strobe cycle in view.
  task automatic measure(input bit wait_first, input bit exp_pol,
                         output int per, output int sec, output int first,
                         output int lvl0);
    if (wait_first) wait_end();
    per = 0; sec = 0; first = -1; lvl0 = int'(pwm_out);
    do begin
      if (pwm_out !== exp_pol) begin
        sec++;
        if (first < 0) first = per;
      end
      per++;
      @(negedge clk);
    end while (!period_end && per < TMO);
    if (first < 0) first = per;
  endtask

  task automatic judge(input string tag, input int tl, input int p, input int d,
                       input bit pl, input bit c, input int per, input int sec,
                       input int first, input int lvl0);
    int pe, dc, mult, e_per, e_sec, e_first;
    pe = (p == 0) ? 1 : p;
    dc = (d > pe) ? pe : d;
    mult = c ? 2 : 1;
    e_per = mult * pe * tl;
    e_sec = mult * (pe - dc) * tl;
    e_first = (d >= pe) ? e_per : d * tl;
    check({tag, (c ? " R5 period" : " R4 period")}, per, e_per);
    check({tag, (c ? " R7 opposite time" : " R6 opposite time")}, sec, e_sec);
    check({tag, (c ? " R7 first edge" : " R6 first edge")}, first, e_first);
    check({tag, " R8 start level"}, lvl0, (d == 0) ? int'(!pl) : int'(pl));
  endtask

  task automatic run_cfg(input string tag, input int sel, input int pa, input int da,
                         input int pb, input int db, input int p, input int d,
                         input bit pl, input bit c);
    int per, sec, first, lvl0;
    apply(sel, pa, da, pb, db, p, d, pl, c);
    measure(1'b1, pl, per, sec, first, lvl0);
    judge(tag, tick_len(sel, pa, da, pb, db), p, d, pl, c, per, sec, first, lvl0);
  endtask

  initial begin
    int c, per, sec, first, lvl0;
    void'($urandom(32'd20250611));

    // R12: reset state
    repeat (3) @(negedge clk);
    check("R12 out in reset", int'(pwm_out), 0);
    check("R12 strobe in reset", int'(period_end), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 out after reset", int'(pwm_out), 0);

    // R11: disabled, output follows polarity, no strobe
    pol = 1'b1; period = 16'd3; duty = 16'd1;
    repeat (3) @(negedge clk);
    check("R11 idle level", int'(pwm_out), 1);
    count_strobes(100, c);
    check("R11 no strobe while idle", c, 0);
    en = 1'b1;

    // R1 R4 R6 R7 R8: basic shapes
    run_cfg("R1 left", 0, 0, 0, 0, 0, 5, 2, 1'b0, 1'b0);
    run_cfg("R1 left scale4", 2, 0, 0, 0, 0, 5, 2, 1'b1, 1'b0);
    run_cfg("R7 center", 0, 0, 0, 0, 0, 5, 2, 1'b0, 1'b1);
    run_cfg("R7 center pol", 1, 0, 0, 0, 0, 6, 3, 1'b1, 1'b1);

    // R9: duty extremes
    run_cfg("R9 zero duty", 0, 0, 0, 0, 0, 5, 0, 1'b0, 1'b0);
    run_cfg("R9 duty eq period", 0, 0, 0, 0, 0, 5, 5, 1'b1, 1'b0);
    run_cfg("R9 duty above period", 0, 0, 0, 0, 0, 5, 9, 1'b0, 1'b1);
    run_cfg("R9 center zero duty", 1, 0, 0, 0, 0, 4, 0, 1'b1, 1'b1);

    // R10: zero period acts as one
    run_cfg("R10 zero period", 0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0);
    run_cfg("R10 zero period center", 1, 0, 0, 0, 0, 0, 1, 1'b0, 1'b1);

    // R10: a change mid-period waits for the boundary
    run_cfg("R10 base", 0, 0, 0, 0, 0, 6, 2, 1'b0, 1'b0);
    wait_end();
    @(negedge clk);
    duty = 16'd4; period = 16'd7;
    measure(1'b0, 1'b0, per, sec, first, lvl0);
    // measurement began one cycle into the period
    check("R10 old period kept", per + 1, 6);
    check("R10 old duty kept", first + 1, 2);
    measure(1'b0, 1'b0, per, sec, first, lvl0);
    judge("R10 new values", 1, 7, 4, 1'b0, 1'b0, per, sec, first, lvl0);

    // R3: silent codes
    apply(13, 0, 0, 0, 0, 4, 2, 1'b0, 1'b0);
    count_strobes(300, c);
    check("R3 code 13 silent", c, 0);
    clk_sel = 4'd15;
    count_strobes(300, c);
    check("R3 code 15 silent", c, 0);

    // R2: dividers
    apply(11, 1, 0, 0, 0, 4, 2, 1'b0, 1'b0);
    count_strobes(300, c);
    check("R2 divider A off", c, 0);
    run_cfg("R2 divider A", 11, 1, 3, 0, 0, 4, 1, 1'b0, 1'b0);
    apply(12, 0, 0, 11, 2, 4, 2, 1'b0, 1'b0);
    count_strobes(300, c);
    check("R2 divider B bad scale", c, 0);
    run_cfg("R2 divider B", 12, 0, 0, 2, 2, 3, 1, 1'b1, 1'b1);

    // R1: largest power-of-two scale
    run_cfg("R1 scale1024", 10, 0, 0, 0, 0, 2, 1, 1'b0, 1'b0);

    // Random mix
    for (int it = 0; it < 30; it++) begin
      int sel, pa, da, pb, db, p, d;
      bit pl, cc;
      case ($urandom_range(0, 5))
        0: sel = 0;
        1: sel = 1;
        2: sel = 2;
        3: sel = 3;
        4: sel = 11;
        default: sel = 12;
      endcase
      pa = $urandom_range(0, 2); da = $urandom_range(1, 4);
      pb = $urandom_range(0, 2); db = $urandom_range(1, 3);
      p = $urandom_range(1, 12); d = $urandom_range(0, 14);
      pl = 1'($urandom_range(0, 1)); cc = 1'($urandom_range(0, 1));
      run_cfg("rand R6 R7", sel, pa, da, pb, db, p, d, pl, cc);
    end

    // R11: disabling mid-run returns to the start level
    apply(0, 0, 0, 0, 0, 8, 0, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 idle level after stop", int'(pwm_out), 1);
    count_strobes(50, c);
    check("R11 no strobe after stop", c, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule